// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is an 8-bit up-counting timer that software reaches through two byte-wide registers on a simple synchronous bus: a count register and a control register. A prescaler divides the system clock by one of eight ratios, and each resulting pulse advances the count while the timer is enabled. When the count wraps past its maximum, the block sets a sticky overflow flag. It also emits a single-cycle request. In interval mode that request is an interrupt. In watchdog mode it is a reset request, and a control bit selects whether the request is power-on style or manual style.

Every write must carry a key in the upper byte of its 16-bit write word, and the data sits in the lower byte. A write with the wrong key does nothing. This guards the timer against stray software writes. Reads return the plain 8-bit register value with no key. The block only produces request pulses; a separate interrupt or reset controller acts on them.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the count register reads 0x00, the control register reads 0x00, and all three request outputs are low.
- R2: A write to address 0 loads the count register with wdata_i[7:0] only when wdata_i[15:8] is 0x5A. Any other key leaves the count unchanged.
- R3: A write to address 1 updates the control register only when wdata_i[15:8] is 0xA5. Any other key leaves every control field unchanged.
- R4: The control register layout is: bit 7 overflow flag, bit 6 mode (1 = watchdog, 0 = interval), bit 5 enable, bit 3 reset kind (0 = power-on, 1 = manual), bits 2:0 clock select. Bit 4 always reads 0 and ignores writes.
- R5: Clock-select codes 0 to 7 divide the clock by 1, 4, 16, 32, 64, 256, 1024 and 4096. The prescaler is held at zero while the timer is disabled. After an enabling write, the count reaches N after exactly N×divisor clock edges.
- R6: When the count wraps from 0xFF to 0x00, the overflow flag becomes 1 on that same edge.
- R7: Writing 0 to the overflow flag with a valid key clears it. Writing 1 leaves it as it was. If an overflow occurs in the same cycle, the flag is set.
- R8: A valid control write with enable = 0 clears the count to 0x00. While the timer is disabled, the count does not advance.
- R9: An overflow in interval mode produces a one-cycle pulse on irq_o in the cycle after the wrap edge's event cycle, that is, visible right after the wrap edge.
- R10: An overflow in watchdog mode produces a one-cycle pulse on por_req_o when the reset kind is 0, or on man_req_o when it is 1. At most one request output is high at any time.
- R11: If a keyed count write and a prescaler pulse fall in the same cycle, the count takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 1 | Register select: 0 = count, 1 = control |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Key in [15:8], data in [7:0] |
| rdata_o | output | 8 | Value of the selected register (combinational) |
| irq_o | output | 1 | Interval-mode overflow interrupt pulse |
| por_req_o | output | 1 | Watchdog power-on-style reset request pulse |
| man_req_o | output | 1 | Watchdog manual-style reset request pulse |

## Verification
Register writes take effect on the clock edge that samples the strobe, so a read issued right after that edge must already show the new value. rdata_o is combinational and follows addr_i with no delay. Both the overflow flag and the request pulses change on the wrap edge itself. After an enabling write, the first count step lands divisor edges later. The bench runs a behavioural model that advances on each rising edge and compares every output half a period later. Its directed checks count edges from the write that starts each scenario and sample after exactly that many edges.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DW    = 8;
  localparam int PRE_W = 12;

  typedef struct packed {
    logic       ovf;
    logic       wd_mode;
    logic       en;
    logic       rsvd;
    logic       rst_kind;
    logic [2:0] csel;
  } ctrl_t;

  // divisor exponents for codes 0..7 : 1,4,16,32,64,256,1024,4096
  function automatic logic [PRE_W-1:0] div_mask(input logic [2:0] code);
    int sh;
    case (code)
      3'd0: sh = 0;
      3'd1: sh = 2;
      3'd2: sh = 4;
      3'd3: sh = 5;
      3'd4: sh = 6;
      3'd5: sh = 8;
      3'd6: sh = 10;
      default: sh = 12;
    endcase
    return PRE_W'((1 << sh) - 1);
  endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale
  import wdog_pkg::*;
#(
  parameter int W = PRE_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] csel_i,
  output logic       tick_o
);
  logic [W-1:0] pre_q;
  logic [W-1:0] mask;

  assign mask   = div_mask(csel_i);
  assign tick_o = en_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pre_q <= '0;
    else if (en_i) pre_q <= pre_q + 1'b1;
    else           pre_q <= '0;
  end

  assert_pre_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> pre_q == '0);
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int          DW  = 8,
  parameter logic [DW-1:0] KEY = 8'h5A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [2*DW-1:0] wdata_i,
  input  logic          clr_i,
  input  logic          tick_i,
  output logic [DW-1:0] cnt_o,
  output logic          evt_o
);
  logic          acc;
  logic [DW-1:0] cnt_q;

  assign acc   = wr_i && (wdata_i[2*DW-1:DW] == KEY);
  assign evt_o = tick_i && !acc && (cnt_q == '1);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (acc)    cnt_q <= wdata_i[DW-1:0]; // write beats tick
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_locked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !acc && !tick_i && !clr_i) |=> $stable(cnt_q));
  assert_cnt_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i && !clr_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_write_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && tick_i) |=> cnt_q == $past(wdata_i[DW-1:0]));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter logic [DW-1:0] KEY = 8'hA5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [2*DW-1:0] wdata_i,
  input  logic          evt_i,
  output ctrl_t         ctrl_o,
  output logic          clr_o,
  output logic          irq_o,
  output logic          por_o,
  output logic          man_o
);
  logic  acc;
  ctrl_t d;
  ctrl_t q;

  assign acc = wr_i && (wdata_i[2*DW-1:DW] == KEY);
  assign d   = ctrl_t'(wdata_i[DW-1:0]);
  assign clr_o  = acc && !d.en;
  assign ctrl_o = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q     <= '0;
      irq_o <= 1'b0;
      por_o <= 1'b0;
      man_o <= 1'b0;
    end else begin
      irq_o <= evt_i && !q.wd_mode;
      por_o <= evt_i && q.wd_mode && !q.rst_kind;
      man_o <= evt_i && q.wd_mode && q.rst_kind;
      if (acc) begin
        q.ovf      <= evt_i | (q.ovf & d.ovf); // only 0 clears
        q.wd_mode  <= d.wd_mode;
        q.en       <= d.en;
        q.rst_kind <= d.rst_kind;
        q.csel     <= d.csel;
      end else begin
        q.ovf <= q.ovf | evt_i;
      end
      q.rsvd <= 1'b0;
    end
  end

  assert_ctrl_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !acc) |=> $stable({q.wd_mode, q.en, q.rst_kind, q.csel}));
  assert_rsvd_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q.rsvd);
  assert_wrap_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> q.ovf);
  assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q.ovf && !(acc && !d.ovf)) |=> q.ovf);
  assert_irq_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  assert_req_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({irq_o, por_o, man_o}));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter logic [DW-1:0] CNT_KEY  = 8'h5A,
  parameter logic [DW-1:0] CTRL_KEY = 8'hA5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            addr_i,
  input  logic            we_i,
  input  logic [2*DW-1:0] wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o,
  output logic            por_req_o,
  output logic            man_req_o
);
  ctrl_t         ctrl;
  logic          tick;
  logic          evt;
  logic          clr;
  logic [DW-1:0] cnt;

  wdog_prescale #(.W(PRE_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ctrl.en),
    .csel_i(ctrl.csel),
    .tick_o(tick)
  );

  wdog_count #(.DW(DW), .KEY(CNT_KEY)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (we_i && !addr_i),
    .wdata_i(wdata_i),
    .clr_i  (clr),
    .tick_i (tick),
    .cnt_o  (cnt),
    .evt_o  (evt)
  );

  wdog_ctrl #(.KEY(CTRL_KEY)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (we_i && addr_i),
    .wdata_i(wdata_i),
    .evt_i  (evt),
    .ctrl_o (ctrl),
    .clr_o  (clr),
    .irq_o  (irq_o),
    .por_o  (por_req_o),
    .man_o  (man_req_o)
  );

  assign rdata_o = addr_i ? {ctrl.ovf, ctrl.wd_mode, ctrl.en, 1'b0, ctrl.rst_kind, ctrl.csel}
                          : cnt;

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.en && !we_i) |=> $stable(cnt));
endmodule

// File: tb/tb_wdog_timer.sv
`timescale 1ns/100ps
module tb_wdog_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        addr_i = 1'b0;
  logic        we_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        irq_o, por_req_o, man_req_o;

  int n_chk = 0, n_bad = 0;
  int n_irq = 0, n_por = 0, n_man = 0;

  always #2 clk_i = ~clk_i; // 250 MHz

  wdog_timer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .por_req_o(por_req_o), .man_req_o(man_req_o)
  );

  // behavioural reference model
  int m_pre, m_cnt;
  bit m_ovf, m_mode, m_en, m_rk;
  int m_cs;
  bit m_irq, m_por, m_man;
  int divs[8] = '{1, 4, 16, 32, 64, 256, 1024, 4096};

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pre = 0; m_cnt = 0; m_ovf = 0; m_mode = 0; m_en = 0; m_rk = 0; m_cs = 0;
      m_irq = 0; m_por = 0; m_man = 0;
    end else begin
      bit cw, kw, tk, ev;
      int dv;
      cw = we_i && !addr_i && wdata_i[15:8] == 8'h5A;
      kw = we_i && addr_i && wdata_i[15:8] == 8'hA5;
      dv = divs[m_cs];
      tk = m_en && (m_pre % dv == dv - 1);
      ev = tk && m_cnt == 255 && !cw;
      m_irq = ev && !m_mode;
      m_por = ev && m_mode && !m_rk;
      m_man = ev && m_mode && m_rk;
      m_pre = m_en ? (m_pre + 1) % 4096 : 0;
      if (cw)                  m_cnt = wdata_i[7:0];
      else if (kw && !wdata_i[5]) m_cnt = 0;
      else if (tk)             m_cnt = (m_cnt + 1) % 256;
      if (kw) begin
        m_ovf  = ev | (m_ovf & wdata_i[7]);
        m_mode = wdata_i[6]; m_en = wdata_i[5]; m_rk = wdata_i[3]; m_cs = wdata_i[2:0];
      end else m_ovf = m_ovf | ev;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, half a period after each rising edge
  always @(negedge clk_i) begin
    #1;
    if (rst_ni) begin
      int exp_rd;
      exp_rd = addr_i ? {m_ovf, m_mode, m_en, 1'b0, m_rk, m_cs[2:0]} : m_cnt;
      chk(addr_i ? "R4 control read" : "R5 count read", rdata_o, exp_rd);
      chk("R9 irq", irq_o, m_irq);
      chk("R10 por", por_req_o, m_por);
      chk("R10 man", man_req_o, m_man);
      n_irq += irq_o; n_por += por_req_o; n_man += man_req_o;
    end
  end

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; we_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic a, input int exp, input string tag);
    addr_i = a;
    #1;
    chk(tag, rdata_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    rd(0, 0, "R1 count after reset");
    rd(1, 0, "R1 control after reset");
    chk("R1 requests after reset", {irq_o, por_req_o, man_req_o}, 0);
    // R2 key on count writes
    wr(0, 16'h1234); rd(0, 8'h00, "R2 wrong key ignored");
    wr(0, 16'h5A34); rd(0, 8'h34, "R2 keyed write");
    // R3 key on control writes
    wr(1, 16'h0021); rd(1, 8'h00, "R3 wrong key ignored");
    // R4 reserved bit, R8 disable clears count
    wr(1, 16'hA59F); rd(1, 8'h0F, "R4 layout and reserved bit");
    rd(0, 8'h00, "R8 disable write clears count");
    // R5 divide by 4
    wr(1, 16'hA521); repeat (40) @(negedge clk_i);
    rd(0, 10, "R5 div4 after 40 edges");
    // R11 write beats tick, R6 wrap, R9 irq
    wr(1, 16'hA520);
    wr(0, 16'h5AFD); rd(0, 8'hFD, "R11 write wins over tick");
    repeat (3) @(negedge clk_i);
    rd(1, 8'hA0, "R6 overflow flag set on wrap");
    repeat (2) @(negedge clk_i);
    chk("R9 one irq pulse", n_irq, 1);
    // R7 overflow clear rules
    wr(1, 16'hA5A0); rd(1, 8'hA0, "R7 writing 1 keeps flag");
    wr(1, 16'hA520); rd(1, 8'h20, "R7 writing 0 clears flag");
    // R8 disabled hold
    wr(1, 16'hA500); rd(0, 0, "R8 count cleared");
    repeat (10) @(negedge clk_i);
    rd(0, 0, "R8 no advance while disabled");
    // R10 watchdog power-on kind
    wr(0, 16'h5AFE); wr(1, 16'hA560);
    repeat (5) @(negedge clk_i);
    chk("R10 por pulse", n_por, 1);
    chk("R10 no man pulse yet", n_man, 0);
    rd(1, 8'hE0, "R6 flag in watchdog mode");
    // R10 watchdog manual kind
    wr(1, 16'hA508); rd(1, 8'h08, "R7 cleared with mode write");
    wr(0, 16'h5AFF); wr(1, 16'hA568);
    repeat (4) @(negedge clk_i);
    chk("R10 man pulse", n_man, 1);
    chk("R10 por unchanged", n_por, 1);
    chk("R9 no irq in watchdog mode", n_irq, 1);
    // R5 larger divisors
    wr(1, 16'hA500); wr(1, 16'hA525); repeat (512) @(negedge clk_i);
    rd(0, 2, "R5 div256 after 512 edges");
    wr(1, 16'hA500); wr(1, 16'hA527); repeat (8192) @(negedge clk_i);
    rd(0, 2, "R5 div4096 after 8192 edges");
    repeat (2) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule